// File: doc/BRIEF.md
# Flash Write-Buffer Sequencer

This block runs the buffered program sequence of a parallel NOR-style flash command set. A command write of 0xE8 arms it. The next bus write supplies a word count and also fixes an aligned window inside the storage array. Data writes that follow are held in a private shadow buffer and do not reach the array. The last cycle is a confirm code. That code either copies the staged window into the array or throws the staged data away.

The shared status register is fed through an 8-bit status output. Bit 7 is the ready flag and bit 4 is the program-error flag. The storage array is reached only through a write port, which the block drives one word per clock during a commit. A command decoder elsewhere in the chip handles every other command. That decoder watches the `win_open`, `busy`, `done` and `abort` outputs.

Top module: `flash_wbuf`

## Requirements
- R1: After reset, `status` is 0x80 (bit 7 ready set, bit 4 program error clear), `win_open` and `busy` are low, and the store port stays idle.
- R2: In the idle state, a bus write whose low byte is 0xE8 sets ready and arms the count cycle. Any other idle write changes nothing.
- R3: On the count cycle, the data is cut to 8·DEV_BYTES bits, or to the bank width when DEV_BYTES is 0. A count of N accepts exactly N+1 data writes, and the write after those is the confirm cycle.
- R4: The window base is the count-cycle address with its low log2(W) bits cleared. W is 2^8 bytes for a 1-byte bank and 2^11 bytes otherwise, multiplied by BANK_BYTES/DEV_BYTES devices. With the default parameters W is 4096 bytes.
- R5: Data writes update only the shadow buffer. The store port is written only while `busy` is high.
- R6: A data write outside the window sets status bit 4, is dropped, and the bit stays set until reset.
- R7: A data write while `array_ro` is high sets status bit 4 and is dropped.
- R8: A confirm whose low byte is 0xD0, made while bit 4 is clear, starts a copy of W/BANK_BYTES clocks. During the copy `busy` is high and ready is low. Words written in the buffer replace their array words, and every other array word keeps its value. A one-cycle `done` pulse then restores ready and closes the window.
- R9: Any other confirm value, or a confirm made with bit 4 set, pulses `abort` for one cycle, leaves the array untouched, closes the window and returns to idle.
- R10: `win_open` is high only while a buffer is active. Reset in mid-sequence drops the buffer, and a later confirm code has no effect.
- R11: Bus writes made during a copy are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_we | input | 1 | Bus write strobe, one write per cycle |
| bus_addr | input | ADDR_W | Byte address of the bus write |
| bus_wdata | input | 8*BANK_BYTES | Bus write data; commands use the low byte |
| array_ro | input | 1 | Array is read-only; data writes fail |
| store_we | output | 1 | Array word write strobe |
| store_addr | output | ADDR_W | Array byte address of the word |
| store_wdata | output | 8*BANK_BYTES | Word to store |
| status | output | 8 | Bit 7 ready, bit 4 program error, others 0 |
| win_open | output | 1 | A buffer window is active |
| busy | output | 1 | Commit copy in progress |
| done | output | 1 | One-cycle pulse when the commit ends |
| abort | output | 1 | One-cycle pulse when the buffer is discarded |

## Verification
The count cycle is driven with a value whose upper byte is non-zero. An unmasked counter would then swallow the confirm, so this separates a masked counter from an unmasked one. Counts of 0, 2 and 3 check the N+1 rule, including the boundary of a single data write. Writes placed at the first word, the last word and an interior word of the window check the alignment and the untouched-word behaviour. A write in a different window and a write with the read-only input raised each produce a discard, which separates the bounds check from the protection check. Non-confirm codes, writes during a copy, and a reset in mid-sequence show that nothing reaches the array when it must not.

// File: rtl/flash_wbuf.sv
module flash_wbuf #(
  parameter int BANK_BYTES = 2,
  parameter int DEV_BYTES  = 1,
  parameter int ADDR_W     = 13
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    bus_we,
  input  logic [ADDR_W-1:0]       bus_addr,
  input  logic [8*BANK_BYTES-1:0] bus_wdata,
  input  logic                    array_ro,
  output logic                    store_we,
  output logic [ADDR_W-1:0]       store_addr,
  output logic [8*BANK_BYTES-1:0] store_wdata,
  output logic [7:0]              status,
  output logic                    win_open,
  output logic                    busy,
  output logic                    done,
  output logic                    abort
);
  localparam int DW       = 8 * BANK_BYTES;
  localparam int NDEV     = (DEV_BYTES != 0) ? BANK_BYTES / DEV_BYTES : 1;
  localparam int WB_SHIFT = (BANK_BYTES == 1) ? 8 : 11;
  localparam int WB_BYTES = (1 << WB_SHIFT) * NDEV;
  localparam int WB_LOG   = $clog2(WB_BYTES);
  localparam int LB       = $clog2(BANK_BYTES);
  localparam int WORDS    = WB_BYTES / BANK_BYTES;
  localparam int IDX_W    = WB_LOG - LB;
  localparam int CNT_W    = 8 * ((DEV_BYTES != 0) ? DEV_BYTES : BANK_BYTES);
  localparam logic [ADDR_W-1:0] WIN_MASK = ADDR_W'(WB_BYTES - 1);
  localparam logic [IDX_W-1:0]  LAST     = IDX_W'(WORDS - 1);

  typedef enum logic [2:0] {S_IDLE, S_COUNT, S_DATA, S_CONF, S_COPY} state_t;

  state_t            st;
  logic              rdy, err, win, done_q, abort_q;
  logic [CNT_W-1:0]  cnt;
  logic [ADDR_W-1:0] base;
  logic [IDX_W-1:0]  cp;
  logic [WORDS-1:0]  mask;
  logic [DW-1:0]     sbuf [WORDS];

  logic [7:0]       cmd;
  logic             in_win, take;
  logic [IDX_W-1:0] widx;

  assign cmd    = bus_wdata[7:0];
  assign in_win = bus_addr[ADDR_W-1:WB_LOG] == base[ADDR_W-1:WB_LOG];
  assign widx   = bus_addr[WB_LOG-1:LB];
  assign take   = (st == S_DATA) && bus_we && in_win && !array_ro;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st      <= S_IDLE;
      rdy     <= 1'b1;
      err     <= 1'b0;
      win     <= 1'b0;
      cnt     <= '0;
      base    <= '0;
      cp      <= '0;
      mask    <= '0;
      done_q  <= 1'b0;
      abort_q <= 1'b0;
    end else begin
      done_q  <= 1'b0;
      abort_q <= 1'b0;
      case (st)
        S_IDLE:
          if (bus_we && cmd == 8'hE8) begin
            rdy <= 1'b1;
            st  <= S_COUNT;
          end
        S_COUNT:
          if (bus_we) begin
            cnt  <= bus_wdata[CNT_W-1:0];
            base <= bus_addr & ~WIN_MASK;
            mask <= '0;
            win  <= 1'b1;
            st   <= S_DATA;
          end
        S_DATA:
          if (bus_we) begin
            if (take) mask[widx] <= 1'b1;
            else      err        <= 1'b1;
            if (cnt == '0) st  <= S_CONF;
            else           cnt <= cnt - CNT_W'(1);
          end
        S_CONF:
          if (bus_we) begin
            if (cmd == 8'hD0 && !err) begin
              cp  <= '0;
              rdy <= 1'b0;
              st  <= S_COPY;
            end else begin
              win     <= 1'b0;
              abort_q <= 1'b1;
              st      <= S_IDLE;
            end
          end
        S_COPY:
          if (cp == LAST) begin
            win    <= 1'b0;
            rdy    <= 1'b1;
            done_q <= 1'b1;
            st     <= S_IDLE;
          end else begin
            cp <= cp + IDX_W'(1);
          end
        default: st <= S_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (take) sbuf[widx] <= bus_wdata;
  end

  assign busy        = st == S_COPY;
  assign store_we    = busy && mask[cp];
  assign store_addr  = base + (ADDR_W'(cp) << LB);
  assign store_wdata = sbuf[cp];
  assign status      = {rdy, 2'b00, err, 4'b0000};
  assign win_open    = win;
  assign done        = done_q;
  assign abort       = abort_q;
endmodule

// File: rtl/flash_wbuf_chk.sv
module flash_wbuf_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       store_we,
  input logic [7:0] status,
  input logic       win_open,
  input logic       busy,
  input logic       done,
  input logic       abort
);
  a_r5_store_only_in_copy: assert property (@(posedge clk) disable iff (!rst_n)
    store_we |-> busy);
  a_r8_copy_not_ready: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !status[7]);
  a_r10_copy_has_window: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> win_open);
  a_r8_done_restores: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (status[7] && !busy && !win_open));
  a_r8_done_follows_copy: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> $past(busy));
  a_r9_abort_closes: assert property (@(posedge clk) disable iff (!rst_n)
    abort |-> (!win_open && !busy));
  a_r9_single_outcome: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({done, abort}));
  a_r6_err_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    status[4] |=> status[4]);
endmodule

bind flash_wbuf flash_wbuf_chk u_chk (
  .clk(clk), .rst_n(rst_n), .store_we(store_we), .status(status),
  .win_open(win_open), .busy(busy), .done(done), .abort(abort)
);

// File: tb/tb_flash_wbuf.sv
module tb_flash_wbuf;
  localparam int CLK_P = 10;
  localparam int AW = 13;
  localparam int NW = 4096;
  localparam int COPY_CYC = 2048;

  logic clk = 1'b0;
  always #(CLK_P/2) clk = ~clk;

  logic rst_n = 1'b0, bus_we = 1'b0, array_ro = 1'b0, mem_load = 1'b1;
  logic [AW-1:0] bus_addr = '0;
  logic [15:0] bus_wdata = '0;
  logic store_we, win_open, busy, done, abort;
  logic [AW-1:0] store_addr;
  logic [15:0] store_wdata;
  logic [7:0] status;

  flash_wbuf #(.BANK_BYTES(2), .DEV_BYTES(1), .ADDR_W(AW)) dut (
    .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .array_ro(array_ro), .store_we(store_we),
    .store_addr(store_addr), .store_wdata(store_wdata), .status(status),
    .win_open(win_open), .busy(busy), .done(done), .abort(abort));

  logic [15:0] mem [NW];
  logic [15:0] exp_m [NW];
  int n_store = 0;
  int vecs = 0, fails = 0, cyc = 0;

  function automatic logic [15:0] pat(int i);
    return 16'(i * 16'h2F + 5);
  endfunction

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (mem_load) begin
      for (int i = 0; i < NW; i++) mem[i] <= pat(i);
    end else if (store_we) begin
      mem[store_addr[AW-1:1]] <= store_wdata;
      n_store <= n_store + 1;
    end
  end

  task automatic check(input bit ok, input string tag, input longint act, input longint expv);
    vecs++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, expv);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; mem_load = 1'b1; bus_we = 1'b0; array_ro = 1'b0;
    for (int i = 0; i < NW; i++) exp_m[i] = pat(i);
    repeat (3) @(negedge clk);
    rst_n = 1'b1; mem_load = 1'b0;
  endtask

  task automatic wr(input logic [AW-1:0] a, input logic [15:0] d);
    @(negedge clk);
    bus_we = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_we = 1'b0;
  endtask

  task automatic wait_copy(output int nbusy, output bit seen);
    nbusy = 0; seen = 1'b0;
    for (int k = 0; k < 3000; k++) begin
      if (done) begin seen = 1'b1; break; end
      if (busy) nbusy++;
      @(negedge clk);
    end
  endtask

  task automatic mem_cmp(input string tag);
    int bad = 0, first = -1;
    for (int i = 0; i < NW; i++)
      if (mem[i] !== exp_m[i]) begin bad++; if (first < 0) first = i; end
    check(bad == 0, tag, bad, 0);
    if (bad != 0) $display("  first mismatch word %0h: %0h vs %0h", first, mem[first], exp_m[first]);
  endtask

  task automatic t_reset();
    do_reset();
    check(status == 8'h80, "R1 status", status, 8'h80);
    check(!win_open && !busy && !store_we, "R1 idle flags", {win_open, busy, store_we}, 0);
  endtask

  task automatic t_commit_masked();
    int nb, s0; bit seen;
    do_reset();
    s0 = n_store;
    wr(13'h1A36, 16'h00E8);
    check(status == 8'h80 && !win_open, "R2 armed", status, 8'h80);
    wr(13'h1A36, 16'h0102);
    check(win_open, "R4 window open", win_open, 1);
    wr(13'h1000, 16'hAAAA); exp_m[13'h1000 >> 1] = 16'hAAAA;
    wr(13'h1A36, 16'hBBBB); exp_m[13'h1A36 >> 1] = 16'hBBBB;
    wr(13'h1FFE, 16'hCCCC); exp_m[13'h1FFE >> 1] = 16'hCCCC;
    check(n_store == s0, "R5 no store before confirm", n_store - s0, 0);
    wr(13'h0000, 16'h00D0);
    wait_copy(nb, seen);
    check(seen, "R8 done pulse", seen, 1);
    check(nb == COPY_CYC, "R8 copy length", nb, COPY_CYC);
    check(status == 8'h80 && !win_open, "R8 ready after copy", status, 8'h80);
    check(n_store - s0 == 3, "R8 store count", n_store - s0, 3);
    mem_cmp("R3 R4 R8 array after masked count 2");
  endtask

  task automatic t_count_edges();
    int nb; bit seen;
    do_reset();
    wr(13'h0800, 16'h00E8);
    wr(13'h0800, 16'h0000);
    wr(13'h0002, 16'h1111); exp_m[1] = 16'h1111;
    wr(13'h0002, 16'h00D0);
    wait_copy(nb, seen);
    check(seen, "R3 count 0 commits after one write", seen, 1);
    wr(13'h0000, 16'h00E8);
    wr(13'h0000, 16'h0003);
    for (int i = 0; i < 4; i++) begin
      wr(13'(13'h0100 + 2*i), 16'(16'h4000 + i));
      exp_m[(13'h0100 >> 1) + i] = 16'(16'h4000 + i);
    end
    check(!busy && win_open && !abort, "R3 still collecting", {busy, win_open}, 1);
    wr(13'h0000, 16'h00D0);
    wait_copy(nb, seen);
    check(seen, "R3 count 3 commits after four writes", seen, 1);
    mem_cmp("R3 array after counts 0 and 3");
  endtask

  task automatic t_abort();
    int s0; bit ab = 1'b0;
    do_reset();
    s0 = n_store;
    wr(13'h1000, 16'h00E8);
    wr(13'h1000, 16'h0000);
    wr(13'h1004, 16'h7777);
    @(negedge clk);
    bus_we = 1'b1; bus_addr = 13'h1000; bus_wdata = 16'h00FF;
    @(negedge clk);
    bus_we = 1'b0; ab = abort;
    check(ab, "R9 abort pulse", ab, 1);
    check(!win_open && status == 8'h80, "R9 window closed", {win_open, status}, 8'h80);
    repeat (2100) @(negedge clk);
    check(n_store == s0, "R9 no store after discard", n_store - s0, 0);
    mem_cmp("R9 array unchanged");
  endtask

  task automatic t_oob();
    int s0; bit ab = 1'b0;
    do_reset();
    s0 = n_store;
    wr(13'h1000, 16'h00E8);
    wr(13'h1000, 16'h0001);
    wr(13'h0010, 16'h9999);
    check(status == 8'h90, "R6 error set", status, 8'h90);
    wr(13'h1010, 16'h8888);
    @(negedge clk);
    bus_we = 1'b1; bus_addr = 13'h1000; bus_wdata = 16'h00D0;
    @(negedge clk);
    bus_we = 1'b0; ab = abort;
    check(ab && !busy, "R6 R9 confirm refused with error", {ab, busy}, 2);
    repeat (2100) @(negedge clk);
    check(n_store == s0, "R6 nothing stored", n_store - s0, 0);
    check(status[4], "R6 error sticky", status, 8'h90);
    mem_cmp("R6 array unchanged");
  endtask

  task automatic t_ro();
    int s0;
    do_reset();
    s0 = n_store;
    wr(13'h0000, 16'h00E8);
    wr(13'h0000, 16'h0000);
    array_ro = 1'b1;
    wr(13'h0020, 16'h5A5A);
    array_ro = 1'b0;
    check(status == 8'h90, "R7 error on read-only", status, 8'h90);
    wr(13'h0000, 16'h00D0);
    repeat (2100) @(negedge clk);
    check(n_store == s0 && !win_open, "R7 nothing stored", n_store - s0, 0);
    mem_cmp("R7 array unchanged");
  endtask

  task automatic t_idle_ignore();
    int s0;
    do_reset();
    s0 = n_store;
    wr(13'h0000, 16'h00FF);
    wr(13'h0000, 16'h0070);
    wr(13'h0000, 16'hE800);
    wr(13'h0000, 16'h0000);
    wr(13'h0000, 16'h00D0);
    repeat (5) @(negedge clk);
    check(!win_open && !busy && status == 8'h80, "R2 idle writes ignored", {win_open, busy}, 0);
    check(n_store == s0, "R2 no store from idle writes", n_store - s0, 0);
  endtask

  task automatic t_busy_ignore();
    int nb; bit seen;
    do_reset();
    wr(13'h1000, 16'h00E8);
    wr(13'h1000, 16'h0000);
    wr(13'h1100, 16'h3C3C); exp_m[13'h1100 >> 1] = 16'h3C3C;
    wr(13'h1000, 16'h00D0);
    wr(13'h1000, 16'h00E8);
    wr(13'h1102, 16'h6666);
    wait_copy(nb, seen);
    check(seen, "R11 copy completes", seen, 1);
    wr(13'h1000, 16'h0000);
    check(!win_open, "R11 command during copy ignored", win_open, 0);
    mem_cmp("R11 array after copy with bus traffic");
  endtask

  task automatic t_reset_mid();
    int s0;
    do_reset();
    wr(13'h1000, 16'h00E8);
    wr(13'h1000, 16'h0001);
    wr(13'h1004, 16'h1234);
    check(win_open, "R10 window open mid-sequence", win_open, 1);
    do_reset();
    s0 = n_store;
    check(!win_open, "R10 reset drops buffer", win_open, 0);
    wr(13'h1006, 16'h2222);
    wr(13'h1000, 16'h00D0);
    repeat (2100) @(negedge clk);
    check(n_store == s0 && !busy && !win_open, "R10 later confirm has no effect", n_store - s0, 0);
  endtask

  initial begin
    t_reset();
    t_commit_masked();
    t_count_edges();
    t_abort();
    t_oob();
    t_ro();
    t_idle_ignore();
    t_busy_ignore();
    t_reset_mid();
    $display("== %0d vectors applied, %0d miscompares ==", vecs, fails);
    $finish;
  end

  initial begin
    wait (cyc > 150000);
    vecs++; fails++;
    $display("FAIL watchdog: actual %0d expected below 150000 cycles", cyc);
    $display("== %0d vectors applied, %0d miscompares ==", vecs, fails);
    $finish;
  end
endmodule